// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Fast-Path Bits

This block gathers 72 level-sensitive interrupt sources into one IRQ line and one FIQ line. The sources form three banks. A small bank of 8 direct sources sits in bank 0. Banks 1 and 2 hold 32 sources each. Software sees the block through a single-cycle, 32-bit register port. The port provides a pending view per bank, an enable mask per bank with separate set and clear write addresses, and a fast-interrupt routing register.

The bank 0 pending word is the word a handler reads first. Beside its own 8 sources, it holds one summary bit per upper bank. It also holds fast-path bits that copy eleven chosen sources of banks 1 and 2. A pending fast-path source does not raise its bank summary bit, so the handler can often skip the second register read. The fast-interrupt register picks any one of the 72 raw inputs by a flat index and routes it straight to the FIQ line.

Top module: `intc_banked_top`

## Requirements
- R1: After reset, all enable masks and the fast-interrupt register are 0, and `irq_o` and `fiq_o` are low.
- R2: A write to a set address ORs the written mask into that bank's enables. A write to a clear address removes the written mask bits. Zero bits leave enables unchanged. Each enable address reads back its current mask.
- R3: A bank 1 or bank 2 pending bit reads 1 exactly while its raw input is high and its enable bit is set. It holds no latched state.
- R4: Bank 0 pending bits 7:0 are its own sources ANDed with the 8-bit bank 0 enable.
- R5: Bank 0 bit 8 (bank 1) and bit 9 (bank 2) are set only while some enabled, pending source of that bank has no fast-path bit.
- R6: Bank 0 bits 10..14 copy bank 1 pending sources 7, 9, 10, 18, 19. Bits 15..20 copy bank 2 pending sources 21, 22, 23, 24, 25, 30. The source's own bank bit reads set too, and it is masked only by its own bank's enable.
- R7: Writes to bank 0 set and clear addresses change only enable bits 7:0. The bank 0 enable reads with bits 31:8 at zero, and the summary and fast-path bits stay as they were.
- R8: `irq_o` is high exactly while any bank 0 pending bit 20:0 is set.
- R9: The fast-interrupt register holds an index in bits 6:0 and an enable in bit 7. Its bits 31:8 read as zero.
- R10: `fiq_o` is the raw level of the indexed source ANDed with bit 7. Index 0..31 selects bank 1, 32..63 selects bank 2 and 64..71 selects bank 0. Index 72..127 selects nothing, so `fiq_o` is 0. Enable masks do not affect `fiq_o`.
- R11: Byte offsets are as follows. Pending: bank 0 at 0x00, bank 1 at 0x04, bank 2 at 0x08. Fast-interrupt register at 0x0C. Set addresses: bank 1 at 0x10, bank 2 at 0x14, bank 0 at 0x18. Clear addresses: bank 1 at 0x1C, bank 2 at 0x20, bank 0 at 0x24. Other offsets read 0 and ignore writes. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_b0_i | input | 8 | Bank 0 source levels |
| src_b1_i | input | 32 | Bank 1 source levels |
| src_b2_i | input | 32 | Bank 2 source levels |
| addr_i | input | ADDR_W (8) | Byte address; bits 1:0 ignored |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that every write lasts one cycle with `we_i` and `addr_i` stable across the sampling edge. They also assume that source levels are already synchronous to `clk_i`, so that a pending or FIQ value changes only between edges. The bench drives every input one time unit after a rising edge and samples on the falling edge. It issues reads only while no write is in flight, so each expected value comes from a settled register state.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW       = 32;
  localparam int B0_SRC   = 8;
  localparam int BANK_SRC = 32;
  localparam int N_FP1    = 5;
  localparam int N_FP2    = 6;
  localparam int SUM1_BIT = 8;
  localparam int SUM2_BIT = 9;
  localparam int FP_BASE  = 10;
  localparam int FIQ_EN_BIT = 7;
  localparam int FIQ_IDX_W  = 7;

  localparam int FP1_SRC [N_FP1] = '{7, 9, 10, 18, 19};
  localparam int FP2_SRC [N_FP2] = '{21, 22, 23, 24, 25, 30};

  localparam int OFF_PEND0 = 'h00;
  localparam int OFF_PEND1 = 'h04;
  localparam int OFF_PEND2 = 'h08;
  localparam int OFF_FIQ   = 'h0C;
  localparam int OFF_SET1  = 'h10;
  localparam int OFF_SET2  = 'h14;
  localparam int OFF_SET0  = 'h18;
  localparam int OFF_CLR1  = 'h1C;
  localparam int OFF_CLR2  = 'h20;
  localparam int OFF_CLR0  = 'h24;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PEND0, SEL_PEND1, SEL_PEND2, SEL_FIQ,
    SEL_SET0, SEL_SET1, SEL_SET2, SEL_CLR0, SEL_CLR1, SEL_CLR2
  } reg_sel_e;

  function automatic logic [BANK_SRC-1:0] fp1_mask();
    logic [BANK_SRC-1:0] m = '0;
    for (int k = 0; k < N_FP1; k++) m[FP1_SRC[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_SRC-1:0] fp2_mask();
    logic [BANK_SRC-1:0] m = '0;
    for (int k = 0; k < N_FP2; k++) m[FP2_SRC[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  output reg_sel_e            sel_o,
  output logic [B0_SRC-1:0]   en0_o,
  output logic [BANK_SRC-1:0] en1_o,
  output logic [BANK_SRC-1:0] en2_o,
  output logic [7:0]          fiq_ctl_o
);
  logic [ADDR_W-1:0] addr_al;
  logic [B0_SRC-1:0] en0_q;
  logic [7:0]        fiq_q;
  logic [BANK_SRC-1:0] en_hi_q [2];

  assign addr_al = {addr_i[ADDR_W-1:2], 2'b00};

  always_comb begin
    case (addr_al)
      ADDR_W'(OFF_PEND0): sel_o = SEL_PEND0;
      ADDR_W'(OFF_PEND1): sel_o = SEL_PEND1;
      ADDR_W'(OFF_PEND2): sel_o = SEL_PEND2;
      ADDR_W'(OFF_FIQ):   sel_o = SEL_FIQ;
      ADDR_W'(OFF_SET0):  sel_o = SEL_SET0;
      ADDR_W'(OFF_SET1):  sel_o = SEL_SET1;
      ADDR_W'(OFF_SET2):  sel_o = SEL_SET2;
      ADDR_W'(OFF_CLR0):  sel_o = SEL_CLR0;
      ADDR_W'(OFF_CLR1):  sel_o = SEL_CLR1;
      ADDR_W'(OFF_CLR2):  sel_o = SEL_CLR2;
      default:            sel_o = SEL_NONE;
    endcase
  end

  // bank 0: only the 8 direct source enables exist
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en0_q <= '0;
      fiq_q <= '0;
    end else if (we_i) begin
      if (sel_o == SEL_SET0) en0_q <= en0_q | wdata_i[B0_SRC-1:0];
      if (sel_o == SEL_CLR0) en0_q <= en0_q & ~wdata_i[B0_SRC-1:0];
      if (sel_o == SEL_FIQ)  fiq_q <= wdata_i[7:0];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam reg_sel_e SET_S = (b == 0) ? SEL_SET1 : SEL_SET2;
    localparam reg_sel_e CLR_S = (b == 0) ? SEL_CLR1 : SEL_CLR2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      en_hi_q[b] <= '0;
      else if (we_i && sel_o == SET_S)  en_hi_q[b] <= en_hi_q[b] | wdata_i;
      else if (we_i && sel_o == CLR_S)  en_hi_q[b] <= en_hi_q[b] & ~wdata_i;
    end
  end

  assign en0_o     = en0_q;
  assign en1_o     = en_hi_q[0];
  assign en2_o     = en_hi_q[1];
  assign fiq_ctl_o = fiq_q;
endmodule

// File: rtl/intc_pend.sv
module intc_pend
  import intc_pkg::*;
(
  input  logic [B0_SRC-1:0]   src_b0_i,
  input  logic [BANK_SRC-1:0] src_b1_i,
  input  logic [BANK_SRC-1:0] src_b2_i,
  input  logic [B0_SRC-1:0]   en0_i,
  input  logic [BANK_SRC-1:0] en1_i,
  input  logic [BANK_SRC-1:0] en2_i,
  output logic [DW-1:0]       pend0_o,
  output logic [BANK_SRC-1:0] pend1_o,
  output logic [BANK_SRC-1:0] pend2_o
);
  localparam logic [BANK_SRC-1:0] FP1_M = fp1_mask();
  localparam logic [BANK_SRC-1:0] FP2_M = fp2_mask();
  localparam int FP2_BASE = FP_BASE + N_FP1;
  localparam int TOP_BIT  = FP2_BASE + N_FP2;

  logic [N_FP1-1:0] fp1;
  logic [N_FP2-1:0] fp2;

  assign pend1_o = src_b1_i & en1_i;
  assign pend2_o = src_b2_i & en2_i;

  for (genvar k = 0; k < N_FP1; k++) begin : g_fp1
    assign fp1[k] = pend1_o[FP1_SRC[k]];
  end
  for (genvar k = 0; k < N_FP2; k++) begin : g_fp2
    assign fp2[k] = pend2_o[FP2_SRC[k]];
  end

  always_comb begin
    pend0_o                        = '0;
    pend0_o[B0_SRC-1:0]            = src_b0_i & en0_i;
    // summary ignores sources already visible as fast-path bits
    pend0_o[SUM1_BIT]              = |(pend1_o & ~FP1_M);
    pend0_o[SUM2_BIT]              = |(pend2_o & ~FP2_M);
    pend0_o[FP2_BASE-1:FP_BASE]    = fp1;
    pend0_o[TOP_BIT-1:FP2_BASE]    = fp2;
  end
endmodule

// File: rtl/intc_fiq.sv
module intc_fiq
  import intc_pkg::*;
(
  input  logic [B0_SRC-1:0]   src_b0_i,
  input  logic [BANK_SRC-1:0] src_b1_i,
  input  logic [BANK_SRC-1:0] src_b2_i,
  input  logic [7:0]          fiq_ctl_i,
  output logic                fiq_o
);
  localparam int N_ALL = 2 * BANK_SRC + B0_SRC;

  logic [N_ALL-1:0]     flat;
  logic [FIQ_IDX_W-1:0] idx;
  logic                 hit;

  // flat order: bank 1, bank 2, bank 0
  assign flat = {src_b0_i, src_b2_i, src_b1_i};
  assign idx  = fiq_ctl_i[FIQ_IDX_W-1:0];

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_ALL; i++)
      if (32'(idx) == i) hit = flat[i];
  end

  assign fiq_o = hit & fiq_ctl_i[FIQ_EN_BIT];
endmodule

// File: rtl/intc_banked_top.sv
module intc_banked_top
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        src_b0_i,
  input  logic [31:0]       src_b1_i,
  input  logic [31:0]       src_b2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  reg_sel_e            sel;
  logic [B0_SRC-1:0]   en0;
  logic [BANK_SRC-1:0] en1, en2, pend1, pend2;
  logic [DW-1:0]       pend0;
  logic [7:0]          fiq_ctl;

  intc_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .sel_o(sel), .en0_o(en0), .en1_o(en1), .en2_o(en2), .fiq_ctl_o(fiq_ctl)
  );

  intc_pend pend_i (
    .src_b0_i, .src_b1_i, .src_b2_i,
    .en0_i(en0), .en1_i(en1), .en2_i(en2),
    .pend0_o(pend0), .pend1_o(pend1), .pend2_o(pend2)
  );

  intc_fiq fiq_i (
    .src_b0_i, .src_b1_i, .src_b2_i, .fiq_ctl_i(fiq_ctl), .fiq_o
  );

  always_comb begin
    case (sel)
      SEL_PEND0:          rdata_o = pend0;
      SEL_PEND1:          rdata_o = pend1;
      SEL_PEND2:          rdata_o = pend2;
      SEL_FIQ:            rdata_o = DW'(fiq_ctl);
      SEL_SET0, SEL_CLR0: rdata_o = DW'(en0);
      SEL_SET1, SEL_CLR1: rdata_o = en1;
      SEL_SET2, SEL_CLR2: rdata_o = en2;
      default:            rdata_o = '0;
    endcase
  end

  assign irq_o = |pend0;
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk
  import intc_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input reg_sel_e            sel,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_o,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [B0_SRC-1:0]   en0,
  input logic [BANK_SRC-1:0] en1,
  input logic [BANK_SRC-1:0] en2,
  input logic [7:0]          fiq_ctl
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (en0 == '0 && en1 == '0 && en2 == '0 && fiq_ctl == '0));

  assert_set_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_SET1) |=> ((en1 & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_CLR2) |=> ((en2 & $past(wdata_i)) == '0));

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en0) && $stable(en1) && $stable(en2) && $stable(fiq_ctl)));

  assert_b0_write_narrow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_SET0 || sel == SEL_CLR0) |-> (rdata_o[31:8] == '0));

  assert_irq_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0 == '0 && en1 == '0 && en2 == '0) |-> !irq_o);

  assert_fiq_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_FIQ) |-> (rdata_o[31:8] == '0));

  assert_fiq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> fiq_ctl[FIQ_EN_BIT]);
endmodule

bind intc_banked_top intc_banked_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .sel(sel), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .en0(en0), .en1(en1), .en2(en2), .fiq_ctl(fiq_ctl)
);

// File: tb/intc_banked_top_tb_top.sv
module intc_banked_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [7:0]  src_b0_i = '0;
  logic [31:0] src_b1_i = '0;
  logic [31:0] src_b2_i = '0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind; // 0 rdata, 1 irq, 2 fiq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  intc_banked_top dut_i (.*);

  always #4 clk_i = ~clk_i;

  // monitor
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? rdata_o : (it.kind == 1) ? 32'(irq_o) : 32'(fiq_o);
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic push(input int k, input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(posedge clk_i); #1;
    addr_i = a;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    push(0, a, e, t);
  endtask

  task automatic srcs(input logic [7:0] s0, input logic [31:0] s1, input logic [31:0] s2);
    @(posedge clk_i); #1;
    src_b0_i = s0; src_b1_i = s1; src_b2_i = s2;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;

    rd(8'h10, 32'h0, "R1 en1 reset");
    rd(8'h14, 32'h0, "R1 en2 reset");
    rd(8'h18, 32'h0, "R1 en0 reset");
    rd(8'h0C, 32'h0, "R1 fiq reset");
    srcs(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    push(1, 8'h00, 32'h0, "R1 irq low with no enables");
    push(2, 8'h00, 32'h0, "R1 fiq low");
    rd(8'h04, 32'h0, "R3 pend1 masked");

    wr(8'h10, 32'h0000_00F0);
    rd(8'h10, 32'h0000_00F0, "R2 set en1");
    wr(8'h10, 32'h0000_0F00);
    rd(8'h10, 32'h0000_0FF0, "R2 set keeps old bits");
    wr(8'h1C, 32'h0000_0030);
    rd(8'h1C, 32'h0000_0FC0, "R2 clear en1");

    srcs(8'h00, 32'h0000_0FFF, 32'h0);
    rd(8'h04, 32'h0000_0FC0, "R3 pend1 level and enable");
    rd(8'h00, 32'h0000_1D00, "R6 fast bits plus R5 summary");
    push(1, 8'h00, 32'h1, "R8 irq high");

    srcs(8'h00, 32'h0000_0680, 32'h0);
    rd(8'h00, 32'h0000_1C00, "R5 summary suppressed by fast-path sources");
    rd(8'h04, 32'h0000_0680, "R6 own bank bits still set");

    wr(8'h14, 32'hFFFF_FFFF);
    srcs(8'h00, 32'h0000_0680, 32'h4000_0000);
    rd(8'h00, 32'h0010_1C00, "R6 bank2 source30 at bit20");
    rd(8'h08, 32'h4000_0000, "R3 pend2");
    srcs(8'h00, 32'h0000_0680, 32'h0000_0001);
    rd(8'h00, 32'h0000_1E00, "R5 bank2 summary");

    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_1E00, "R7 clear0 leaves upper bits");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0000_00FF, "R7 en0 only 8 bits");
    srcs(8'h05, 32'h0000_0680, 32'h0000_0001);
    rd(8'h00, 32'h0000_1E05, "R4 bank0 own sources");
    wr(8'h24, 32'h0000_0001);
    rd(8'h00, 32'h0000_1E04, "R4 bank0 source masked");

    wr(8'h1C, 32'h0000_0680);
    rd(8'h00, 32'h0000_0204, "R6 fast bits masked in own bank");

    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0, "R11 unmapped reads zero");
    rd(8'h10, 32'h0000_0940, "R11 unmapped write ignored");

    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    srcs(8'hFF, 32'h0000_0000, 32'h0);
    push(1, 8'h00, 32'h0, "R8 irq low when bank0 word clear");

    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0000_00FF, "R9 fiq upper bits zero");
    push(2, 8'h00, 32'h0, "R10 index 127 selects nothing");

    wr(8'h0C, 32'h0000_0080 | 32'd40);
    srcs(8'h00, 32'h0, 32'h0000_0100);
    push(2, 8'h00, 32'h1, "R10 bank2 index 40 ignores enable");
    push(1, 8'h00, 32'h0, "R10 irq stays low on fiq route");
    wr(8'h0C, 32'h0000_0080 | 32'd65);
    srcs(8'h02, 32'h0, 32'h0);
    push(2, 8'h00, 32'h1, "R10 bank0 index 65");
    wr(8'h0C, 32'h0000_0080 | 32'd3);
    srcs(8'h00, 32'h0000_0008, 32'h0);
    push(2, 8'h00, 32'h1, "R10 bank1 index 3");
    wr(8'h0C, 32'h0000_0003);
    push(2, 8'h00, 32'h0, "R10 enable bit clear");

    @(posedge clk_i);
    @(posedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule